// File: doc/BRIEF.md
# Shared-Line Serial Converter Reader

This block sits on the host side of a delta-sigma converter. The converter has one output pin that does two jobs. While the converter is busy the pin sits high. A low level means a fresh 24-bit result is waiting, and the same pin then carries that result, one bit per serial clock. The reader watches the pin through a synchronizer. Once it sees the low level it drives the serial clock itself and assembles the word MSB first. It then presents the word on a parallel bus together with a single-cycle strobe.

The serial clock's high and low phases are each a fixed number of system clock cycles, set by a parameter. With the default of 10 cycles at 100 MHz, each phase lasts 100 ns. An input selects whether a 25th clock pulse follows the data. That extra pulse makes the converter pull the pin high at once, so the host can keep polling the same pin. Without it, the pin keeps the level of the last bit until the converter's next update. The reader therefore will not start a new read until it has seen the pin high again. The whole read takes about 50 phase lengths, which is far inside one conversion period.

Top module: `adc_ready_reader`

## Requirements
- R1: While reset is held, the serial clock output is 0, the valid strobe is 0 and the result bus is all zeros.
- R2: No serial clock pulse is produced while the data line stays high. A read starts only after the synchronized line is seen low.
- R3: Every high phase of the serial clock lasts exactly HALF_CYC system clock cycles. Every low phase lasts at least HALF_CYC cycles.
- R4: The line level present at the falling edge of serial clock pulse k (k = 1..24) becomes result bit 24-k. The first captured bit is therefore bit 23 (MSB) and the last is bit 0.
- R5: The valid strobe is high for exactly one system clock cycle per read. It rises in the same cycle in which the serial clock falls for the 24th time.
- R6: With the extra-pulse input at 1 when a read starts, the read produces 25 serial clock rising edges. With it at 0, the read produces 24.
- R7: After a read, a line that stays low does not start another read. The line must first be seen high and then low again.
- R8: The result bus changes only in a cycle where the valid strobe is high. It holds the last word until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdata_i | input | 1 | Combined ready flag and serial data from the converter (asynchronous) |
| flush_en_i | input | 1 | 1 = issue a 25th serial clock pulse after the data; sampled when a read starts |
| sclk_o | output | 1 | Serial clock to the converter |
| result_o | output | DATA_W | Last completed conversion word |
| valid_o | output | 1 | One-cycle strobe marking a new word on result_o |

## Verification
The bench models the converter at the pin level. It places bit 24-k on the line at the k-th rising edge of the serial clock and releases the line to high after the 25th edge. It reads patterns that expose bit order and edge loss: all zeros, all ones, a lone MSB, a lone LSB, alternating bits and random words. A reversed shift order, or sampling one edge early or late, shows up there as a mirrored or shifted word. After a read without the extra pulse that ends on a 0 bit, the bench holds the line low. A reader that re-arms on a level instead of a high-to-low sequence would start a phantom read and raise a second strobe. The bench also counts rising edges per read and measures every phase width. A missing or doubled 25th pulse, or a phase shortened by an off-by-one in the timer, is caught there.

// File: rtl/adc_rdr_pkg.sv
package adc_rdr_pkg;

    // Sequencer states of the reader.
    typedef enum logic [2:0] {
        ST_SETTLE = 3'd0,   // clock held low for one phase before arming
        ST_ARM    = 3'd1,   // wait for the line to read high
        ST_WAIT   = 3'd2,   // wait for the line to drop (data ready)
        ST_HIGH   = 3'd3,   // serial clock high phase of a data pulse
        ST_LOW    = 3'd4,   // serial clock low phase of a data pulse
        ST_XHIGH  = 3'd5    // high phase of the extra release pulse
    } seq_state_e;

endpackage

// File: rtl/adc_rdr_sync.sv
module adc_rdr_sync #(
    parameter int  STAGES    = 2,
    parameter bit  RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/adc_rdr_shifter.sv
module adc_rdr_shifter #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic              last_o,
    output logic [DATA_W-1:0] word_o,
    output logic              valid_o
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sreg;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] word;
        logic              valid;
    } shf_t;

    shf_t cur_q, nxt_d;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        shifted     = {cur_q.sreg[DATA_W-2:0], bit_i};
        if (shift_i) begin
            nxt_d.sreg = shifted;
            if (cur_q.idx == IDX_LAST) begin
                // Final bit of the word: publish and restart the index.
                nxt_d.idx   = '0;
                nxt_d.word  = shifted;
                nxt_d.valid = 1'b1;
            end else begin
                nxt_d.idx = cur_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign last_o  = (cur_q.idx == IDX_LAST);
    assign word_o  = cur_q.word;
    assign valid_o = cur_q.valid;

endmodule

// File: rtl/adc_rdr_seq.sv
module adc_rdr_seq
    import adc_rdr_pkg::*;
#(
    parameter int HALF_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,     // synchronized data line
    input  logic flush_i,    // request for the release pulse
    input  logic last_i,     // next capture completes the word
    output logic sclk_o,
    output logic shift_o     // capture strobe, active in the last high cycle
);

    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HALF_CYC - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             sclk;
        logic             flush;
        logic             done;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic expired;

    always_comb begin
        nxt_d   = cur_q;
        shift_o = 1'b0;
        expired = (cur_q.cnt == '0);

        unique case (cur_q.state)
            ST_SETTLE: begin
                if (expired) begin
                    nxt_d.state = ST_ARM;
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end

            ST_ARM: begin
                if (line_i) begin
                    nxt_d.state = ST_WAIT;
                end
            end

            ST_WAIT: begin
                if (!line_i) begin
                    nxt_d.state = ST_HIGH;
                    nxt_d.sclk  = 1'b1;
                    nxt_d.cnt   = RELOAD;
                    nxt_d.flush = flush_i;
                    nxt_d.done  = 1'b0;
                end
            end

            ST_HIGH: begin
                if (expired) begin
                    // Falling edge: the bit has been stable for the whole phase.
                    shift_o     = 1'b1;
                    nxt_d.done  = last_i;
                    nxt_d.sclk  = 1'b0;
                    nxt_d.cnt   = RELOAD;
                    nxt_d.state = ST_LOW;
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end

            ST_LOW: begin
                if (expired) begin
                    if (!cur_q.done) begin
                        nxt_d.state = ST_HIGH;
                        nxt_d.sclk  = 1'b1;
                        nxt_d.cnt   = RELOAD;
                    end else if (cur_q.flush) begin
                        nxt_d.state = ST_XHIGH;
                        nxt_d.sclk  = 1'b1;
                        nxt_d.cnt   = RELOAD;
                    end else begin
                        nxt_d.state = ST_ARM;
                    end
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end

            ST_XHIGH: begin
                if (expired) begin
                    nxt_d.sclk  = 1'b0;
                    nxt_d.cnt   = RELOAD;
                    nxt_d.state = ST_SETTLE;
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end

            default: begin
                nxt_d.state = ST_SETTLE;
                nxt_d.sclk  = 1'b0;
                nxt_d.cnt   = RELOAD;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.state <= ST_SETTLE;
            cur_q.cnt   <= RELOAD;
            cur_q.sclk  <= 1'b0;
            cur_q.flush <= 1'b0;
            cur_q.done  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sclk_o = cur_q.sclk;

endmodule

// File: rtl/adc_ready_reader.sv
module adc_ready_reader #(
    parameter int DATA_W      = 24,
    parameter int HALF_CYC    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata_i,
    input  logic              flush_en_i,
    output logic              sclk_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o
);

    // The bit is captured HALF_CYC cycles after the rising edge; the
    // synchronizer must have delivered it one cycle before that.
    localparam int MIN_HALF = SYNC_STAGES + 1;

    generate
        if (HALF_CYC < MIN_HALF) begin : g_bad_half
            $error("HALF_CYC too small for the synchronizer depth");
        end
    endgenerate

    logic line_sync;
    logic shift_en;
    logic last_bit;

    adc_rdr_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sdata_i),
        .dout  (line_sync)
    );

    adc_rdr_seq #(
        .HALF_CYC (HALF_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (line_sync),
        .flush_i (flush_en_i),
        .last_i  (last_bit),
        .sclk_o  (sclk_o),
        .shift_o (shift_en)
    );

    adc_rdr_shifter #(
        .DATA_W (DATA_W)
    ) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_en),
        .bit_i   (line_sync),
        .last_o  (last_bit),
        .word_o  (result_o),
        .valid_o (valid_o)
    );

endmodule

// File: rtl/adc_rdr_chk.sv
module adc_rdr_chk #(
    parameter int DATA_W   = 24,
    parameter int HALF_CYC = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              valid,
    input logic [DATA_W-1:0] result
);

    localparam int RUN_W = 16;
    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

    logic [RUN_W-1:0] hi_run_q;
    logic [RUN_W-1:0] lo_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else if (sclk) begin
            hi_run_q <= (hi_run_q == RUN_MAX) ? hi_run_q : hi_run_q + 1'b1;
            lo_run_q <= '0;
        end else begin
            lo_run_q <= (lo_run_q == RUN_MAX) ? lo_run_q : lo_run_q + 1'b1;
            hi_run_q <= '0;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sclk && !valid && result == '0));

    a_r3_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_run_q == RUN_W'(HALF_CYC)));

    a_r3_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (lo_run_q >= RUN_W'(HALF_CYC)));

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r5_strobe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $fell(sclk));

    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> valid);

endmodule

bind adc_ready_reader adc_rdr_chk #(
    .DATA_W   (DATA_W),
    .HALF_CYC (HALF_CYC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk   (sclk_o),
    .valid  (valid_o),
    .result (result_o)
);

// File: tb/tb_adc_ready_reader.sv
module tb_adc_ready_reader;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 24;
    localparam int HALF_CYC   = 10;
    localparam int WD_CYCLES  = 180000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush_en = 1'b0;
    logic              sdata;
    logic              sclk;
    logic [DATA_W-1:0] result;
    logic              valid;

    // Converter model state
    logic              reading = 1'b0;
    logic [DATA_W-1:0] cur_word = '0;
    int unsigned       rise_total = 0;
    int unsigned       rise_base  = 0;
    int unsigned       rel_rises;

    // Monitor state
    int unsigned valid_total = 0;
    logic        prev_sclk = 1'b0;
    logic        fell_at_valid = 1'b1;
    int unsigned run_len = 0;
    int unsigned hi_min = 32'hFFFF_FFFF;
    int unsigned hi_max = 0;
    int unsigned lo_min = 32'hFFFF_FFFF;

    int unsigned checks = 0;
    int unsigned errors = 0;
    logic        finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_ready_reader #(
        .DATA_W   (DATA_W),
        .HALF_CYC (HALF_CYC)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sdata_i    (sdata),
        .flush_en_i (flush_en),
        .sclk_o     (sclk),
        .result_o   (result),
        .valid_o    (valid)
    );

    // Converter: k-th rising edge presents bit DATA_W-k, edge 25 releases high.
    always @(posedge sclk) rise_total <= rise_total + 1;

    assign rel_rises = rise_total - rise_base;
    assign sdata = !reading ? 1'b1 :
                   (rel_rises == 0) ? 1'b0 :
                   (rel_rises <= DATA_W) ? cur_word[DATA_W - rel_rises] : 1'b1;

    // Port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid) begin
                valid_total <= valid_total + 1;
                if (!(prev_sclk == 1'b1 && sclk == 1'b0)) fell_at_valid <= 1'b0;
            end
            if (sclk == prev_sclk) begin
                run_len <= run_len + 1;
            end else begin
                if (prev_sclk) begin
                    if (run_len < hi_min) hi_min <= run_len;
                    if (run_len > hi_max) hi_max <= run_len;
                end else if (run_len < lo_min) begin
                    lo_min <= run_len;
                end
                run_len <= 1;
            end
            prev_sclk <= sclk;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [DATA_W-1:0] word, input bit flush);
        int unsigned v0;
        int unsigned rb;
        int          waited;
        logic [DATA_W-1:0] got;
        @(negedge clk);
        flush_en  = flush;
        cur_word  = word;
        rise_base = rise_total;
        v0        = valid_total;
        reading   = 1'b1;
        waited    = 0;
        while (!valid && waited < 60 * HALF_CYC) begin
            @(negedge clk);
            waited++;
        end
        got = result;
        check(valid == 1'b1, "R5 strobe seen", valid, 1);
        check(got == word, "R4 word MSB first", got, word);
        idle(3 * HALF_CYC + 5);
        check(rel_rises == (flush ? 25 : 24), "R6 rising edges per read", rel_rises, flush ? 25 : 24);
        check(valid_total - v0 == 1, "R5 one-cycle strobe", valid_total - v0, 1);
        check(fell_at_valid == 1'b1, "R5 strobe with 24th fall", fell_at_valid, 1);
        if (!flush && word[0] == 1'b0) begin
            // Line stays at the low last bit: must not restart (R7).
            rb = rel_rises;
            v0 = valid_total;
            idle(20 * HALF_CYC);
            check(rel_rises == rb, "R7 no restart on stale low", rel_rises, rb);
            check(valid_total == v0, "R7 no phantom strobe", valid_total - v0, 0);
        end
        reading = 1'b0;
        idle(10);
        check(result == word, "R8 result held", result, word);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog actual %0d expected %0d", WD_CYCLES, 0);
            $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] w;
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        check(sclk == 1'b0 && valid == 1'b0, "R1 reset outputs", {sclk, valid}, 0);
        check(result == '0, "R1 reset result", result, 0);
        @(negedge clk);
        rst_n = 1'b1;

        idle(100);
        check(rise_total == 0, "R2 no clock while line high", rise_total, 0);
        check(valid_total == 0, "R2 no strobe while line high", valid_total, 0);

        // Directed patterns
        do_read(24'h000000, 1'b0);
        do_read(24'hFFFFFF, 1'b1);
        do_read(24'h800000, 1'b0);
        do_read(24'h000001, 1'b1);
        do_read(24'hAAAAAA, 1'b0);
        do_read(24'h555555, 1'b1);
        do_read(24'h7FFFFE, 1'b0);

        // Random words and modes
        for (int i = 0; i < 40; i++) begin
            w = DATA_W'($urandom);
            do_read(w, 1'($urandom % 2));
        end

        check(hi_min == HALF_CYC && hi_max == HALF_CYC, "R3 high phase width", hi_min, HALF_CYC);
        check(lo_min >= HALF_CYC, "R3 low phase width", lo_min, HALF_CYC);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule